// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two signed two's-complement operands, 32 bits each by default, and returns a 64-bit signed product. It uses one adder/subtractor and spends many clock cycles on each product. It suits designs where multiplications are rare enough that a full array multiplier would waste area. A small control machine steps a datapath made of four registers: the multiplicand, a multiplier that shifts right, and a high and a low partial-product half.

A start pulse seen while the block is idle captures both operands and clears the partial product. An add cycle and a shift cycle then follow for each multiplier bit. In each add cycle, the lowest multiplier bit selects whether the multiplicand or zero is added to the high half. In the final add cycle the block subtracts instead of adding, which gives the sign bit of the multiplier its negative weight. Each shift cycle moves the whole partial product one place to the right. The high half is sign-extended from a sum that is one bit wider than the operands. When the last shift is done, the block raises `done` for one cycle, and the product stays on the output until the next accepted start.

Top module: `seq_signed_mult`

## Requirements
- R1: While reset is high and on the first cycle after it, `done` is 0 and `product` is all zeros.
- R2: For any signed operands `op_a` and `op_b` sampled with `start`, `product` equals their exact signed product as a 64-bit two's-complement value.
- R3: `done` is high for exactly one cycle. It rises at the 65th rising edge after the edge that sampled `start` high in idle: one load cycle, then 32 add cycles and 32 shift cycles that alternate.
- R4: After `done`, `product` holds its value, unchanged, for as long as no new start is accepted.
- R5: A `start` pulse that arrives while a multiplication is in progress is ignored. The running operation keeps its operands, its result and its completion cycle.
- R6: The control sequence is idle, then load, then add and shift alternating. An iteration counter stays below the operand width, and after the last shift the control returns to idle.
- R7: Corner operands give exact results: zero times any value is 0, −1 times −1 is 1, the most negative value squared is 2^62, and the most positive value times the most negative value is −(2^31−1)·2^31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the block acts on rising edges |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a multiplication; accepted only while idle |
| op_a | input | 32 | Multiplicand, signed |
| op_b | input | 32 | Multiplier, signed |
| product | output | 64 | Signed product, from registers |
| done | output | 1 | One-cycle pulse when the product is ready |

## Verification
The start edge is the rising edge that samples `start` high while the block is idle. The product and `done` are due at the 65th rising edge after it. The bench's driver records that edge number along with the expected product in a queue. The monitor samples on falling edges and checks that every `done` pulse falls exactly on the recorded cycle, carries the expected value, and is low again on the next cycle. Starts sent while the block is busy are never queued, so an extra result or a shifted completion shows up as a mismatch.

// File: rtl/mult_pkg.sv
package mult_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_ADD   = 2'd2,
    ST_SHIFT = 2'd3
  } mstate_t;
endpackage

// File: rtl/mult_addsub.sv
module mult_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opd,
  input  logic         use_opd,
  input  logic         sub,
  output logic [W:0]   res
);
  logic [W:0] ext_acc;
  logic [W:0] ext_op;

  always_comb begin
    ext_acc = {acc[W-1], acc};
    ext_op  = use_opd ? {opd[W-1], opd} : '0;
    res     = sub ? (ext_acc - ext_op) : (ext_acc + ext_op);
  end
endmodule

// File: rtl/mult_ctrl.sv
module mult_ctrl
  import mult_pkg::*;
#(
  parameter int W = 32
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  output mstate_t state,
  output logic    load_en,
  output logic    add_en,
  output logic    shift_en,
  output logic    sub_sel,
  output logic    done
);
  localparam int CW = $clog2(W) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] iter;
  logic          last;

  always_comb begin
    last     = (iter == LAST);
    load_en  = (state == ST_IDLE) && start;
    add_en   = (state == ST_ADD);
    shift_en = (state == ST_SHIFT);
    sub_sel  = add_en && last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      iter  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE:  if (start) state <= ST_LOAD;
        ST_LOAD: begin
          iter  <= '0;
          state <= ST_ADD;
        end
        ST_ADD:   state <= ST_SHIFT;
        ST_SHIFT: begin
          if (last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            iter  <= iter + 1'b1;
            state <= ST_ADD;
          end
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R6: every add cycle is followed by a shift cycle
  p_add_then_shift_r6: assert property (@(posedge clk) disable iff (rst)
    state == ST_ADD |=> state == ST_SHIFT);

  // R6: the iteration counter stays within the operand width
  p_iter_range_r6: assert property (@(posedge clk) disable iff (rst)
    iter < CW'(W));

  // R3: done lasts one cycle only
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: done comes only out of a shift cycle
  p_done_after_shift_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == ST_IDLE && $past(state) == ST_SHIFT));

  // R5: a start while busy never restarts the load
  p_busy_ignores_start_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADD || state == ST_SHIFT) && start |=> state != ST_LOAD);
endmodule

// File: rtl/mult_datapath.sv
module mult_datapath #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_en,
  input  logic           add_en,
  input  logic           shift_en,
  input  logic           sub_sel,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] product
);
  logic [W-1:0] mcand;
  logic [W-1:0] mplier;
  logic [W-1:0] hi_pp;
  logic [W-1:0] lo_pp;
  logic         xbit;
  logic [W:0]   sum;

  mult_addsub #(.W(W)) u_addsub (
    .acc     (hi_pp),
    .opd     (mcand),
    .use_opd (mplier[0]),
    .sub     (sub_sel),
    .res     (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand  <= '0;
      mplier <= '0;
      hi_pp  <= '0;
      lo_pp  <= '0;
      xbit   <= 1'b0;
    end else if (load_en) begin
      mcand  <= op_a;
      mplier <= op_b;
      hi_pp  <= '0;
      lo_pp  <= '0;
      xbit   <= 1'b0;
    end else if (add_en) begin
      hi_pp <= sum[W-1:0];
      xbit  <= sum[W];
    end else if (shift_en) begin
      hi_pp  <= {xbit, hi_pp[W-1:1]};
      lo_pp  <= {hi_pp[0], lo_pp[W-1:1]};
      mplier <= {1'b0, mplier[W-1:1]};
    end
  end

  assign product = {hi_pp, lo_pp};

  // R2: the bit leaving the high half enters the low half
  p_shift_link_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> lo_pp[W-1] == $past(hi_pp[0]));

  // R4: with no load, add or shift the product holds
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !load_en && !add_en && !shift_en |=> $stable(product));
endmodule

// File: rtl/seq_signed_mult.sv
module seq_signed_mult
  import mult_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] product,
  output logic           done
);
  mstate_t state;
  logic    load_en;
  logic    add_en;
  logic    shift_en;
  logic    sub_sel;

  mult_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .state    (state),
    .load_en  (load_en),
    .add_en   (add_en),
    .shift_en (shift_en),
    .sub_sel  (sub_sel),
    .done     (done)
  );

  mult_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .add_en   (add_en),
    .shift_en (shift_en),
    .sub_sel  (sub_sel),
    .op_a     (op_a),
    .op_b     (op_b),
    .product  (product)
  );

  // R6: a load is always followed by the first add cycle
  p_load_then_add_r6: assert property (@(posedge clk) disable iff (rst)
    state == ST_LOAD |=> state == ST_ADD);
endmodule

// File: tb/sim_seq_signed_mult.sv
module sim_seq_signed_mult;
  localparam int W = 32;

  typedef struct {
    logic [2*W-1:0] prod;
    int             due;
    string          tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   op_a = '0;
  logic [W-1:0]   op_b = '0;
  logic [2*W-1:0] product;
  logic           done;

  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  exp_t sb[$];
  logic [2*W-1:0] last_prod = '0;
  bit   finished = 0;

  seq_signed_mult #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .op_a(op_a), .op_b(op_b), .product(product), .done(done)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [2*W-1:0] act,
                     input logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] smul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] ea, eb;
    ea = {{W{a[W-1]}}, a};
    eb = {{W{b[W-1]}}, b};
    return ea * eb;
  endfunction

  // driver: pulses start at a falling edge, queues expectation
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input string tag,
                     input bit poke_busy);
    exp_t e;
    @(negedge clk);
    op_a  = a;
    op_b  = b;
    start = 1'b1;
    e.prod = smul(a, b);
    e.due  = cyc + 1 + 65;
    e.tag  = tag;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    op_a  = ~a;
    op_b  = b + 1;
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      start = 1'b1;          // R5: ignored while busy
      repeat (3) @(negedge clk);
      start = 1'b0;
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R5 unexpected done", product, '0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(product == e.prod, {"R2 ", e.tag}, product, e.prod);
        chk(cyc == e.due, "R3 completion cycle", 64'(cyc), 64'(e.due));
        last_prod = product;
        @(negedge clk);
        chk(!done, "R3 done single cycle", {63'b0, done}, '0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", {63'b0, done}, '0);
    chk(product == '0, "R1 product in reset", product, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && product == '0, "R1 after reset", product, '0);

    run(32'd0, 32'h1234_5678, "R7 zero", 0);
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 minus one squared", 0);
    run(32'h8000_0000, 32'h8000_0000, "R7 most negative squared", 0);
    chk(last_prod == 64'h4000_0000_0000_0000, "R7 2^62", last_prod, 64'h4000_0000_0000_0000);
    run(32'h7FFF_FFFF, 32'h8000_0000, "R7 max times min", 0);
    run(32'd7, 32'hFFFF_FFFD, "R2 positive times negative", 0);
    run(32'h0001_0003, 32'h0000_0005, "R5 busy start", 1);

    // R4: product held while idle
    repeat (10) @(negedge clk);
    chk(product == last_prod, "R4 product held", product, last_prod);
    chk(done == 1'b0, "R6 back in idle", {63'b0, done}, '0);

    for (int i = 0; i < 40; i++) begin
      run($urandom, $urandom, "R2 random", (i % 8) == 3);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      chk(1'b0, "watchdog", 64'(cyc), '0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule